// File: doc/BRIEF.md
# Multi-Channel Virtual Watchdog Aggregator

This block holds a bank of small down-counters, one per software task that must prove it is still alive. Software refreshes a channel by writing a channel number and a count. A periodic tick from elsewhere in the chip decrements every channel that is not already at zero. After each tick, if every channel is still above zero, the block sends a one-cycle kick to the real hardware watchdog.

When any channel reaches zero, the block latches a fault and never kicks again. Further refresh writes are then discarded, so the hardware watchdog runs out and resets the system. A per-channel expired vector shows which task stopped reporting. Only reset clears the fault.

Top module: `vwdog_aggregator`

## Requirements
- R1: After reset every channel holds INIT_VAL. `expired`, `fault` and `kick` are all low.
- R2: A write with `load_en` high, `load_idx` = i (i < NUM_CH) and `fault` low puts `load_val` into channel i at the next clock edge. The channel then reaches zero after exactly `load_val` ticks.
- R3: In a cycle with `tick` high, every channel that is not being loaded and is nonzero drops by one. A channel at zero stays at zero and does not wrap.
- R4: If a write and a tick hit the same channel in the same cycle, the written value is stored and that channel is not decremented. The other channels still decrement.
- R5: `kick` is high for exactly the one cycle after a cycle with `tick` high. It is high only when no channel is zero after that tick and `fault` is low.
- R6: `fault` goes high at the clock edge that follows any cycle in which some channel is zero. It stays high until reset.
- R7: While `fault` is high, writes have no effect: no `expired` bit falls.
- R8: `expired[i]` is high exactly when channel i holds zero.
- R9: A write whose `load_idx` is NUM_CH or larger changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Refresh write strobe |
| load_idx | input | IDX_W | Channel number of the write |
| load_val | input | CNT_W | Count written into the channel |
| tick | input | 1 | Periodic decrement strobe |
| kick | output | 1 | One-cycle refresh strobe to the hardware watchdog |
| fault | output | 1 | Sticky flag: some channel ran out |
| expired | output | NUM_CH | Per-channel zero indication |

## Verification
A refresh write and a decrement tick can land in the same cycle. They may hit the same channel or different channels. The bench drives both together: repeated same-channel writes with ticks must hold the count, while the other channels keep draining. A channel's expiry and a write can also coincide around the edge where the fault latches. The bench compares each cycle against an arithmetic reference model that applies write priority, saturation and the one-edge fault delay.

// File: rtl/vwdog_pkg.sv
package vwdog_pkg;

   // Width of a channel index. It never drops below one bit.
   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // Smallest power of two that is at least n.
   function automatic int pow2_ceil(input int n);
      int p;
      p = 1;
      while (p < n) p = p * 2;
      return p;
   endfunction

endpackage

// File: rtl/vwdog_channel.sv
module vwdog_channel #(
   parameter int CNT_W    = 8,
   parameter int INIT_VAL = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_hit,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             zero_o
);

   localparam logic [CNT_W-1:0] INIT_C = CNT_W'(INIT_VAL);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= INIT_C;
      else if (load_hit)
         cnt_q <= load_val;            // a write beats the decrement
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - ONE_C;       // stops at zero
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/vwdog_any_zero.sv
module vwdog_any_zero #(
   parameter int NUM_CH = 8,
   parameter bit TREE   = 1'b1
) (
   input  logic [NUM_CH-1:0] vec_i,
   output logic              any_o
);
   import vwdog_pkg::*;

   localparam int P = pow2_ceil(NUM_CH);

   generate
      if (!TREE || NUM_CH == 1) begin : g_flat
         assign any_o = |vec_i;
      end else begin : g_tree
         logic [2*P-1:0] node;
         assign node[0] = 1'b0;
         for (genvar i = 0; i < P; i++) begin : g_leaf
            if (i < NUM_CH) begin : g_used
               assign node[P+i] = vec_i[i];
            end else begin : g_pad
               assign node[P+i] = 1'b0;
            end
         end
         for (genvar k = 1; k < P; k++) begin : g_inner
            assign node[k] = node[2*k] | node[2*k+1];
         end
         assign any_o = node[1];
      end
   endgenerate

endmodule

// File: rtl/vwdog_kick_ctrl.sv
module vwdog_kick_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic any_zero,
   output logic kick,
   output logic fault
);

   logic tick_d;
   logic fault_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_d  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         tick_d  <= tick;
         fault_q <= fault_q | any_zero;
      end
   end

   // The counters already hold their post-tick values in this cycle.
   assign kick  = tick_d & ~any_zero & ~fault_q;
   assign fault = fault_q;

endmodule

// File: rtl/vwdog_aggregator.sv
module vwdog_aggregator #(
   parameter int NUM_CH   = 8,
   parameter int CNT_W    = 8,
   parameter int INIT_VAL = 255,
   parameter bit OR_TREE  = 1'b1,
   localparam int IDX_W   = vwdog_pkg::idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [IDX_W-1:0]  load_idx,
   input  logic [CNT_W-1:0]  load_val,
   input  logic              tick,
   output logic              kick,
   output logic              fault,
   output logic [NUM_CH-1:0] expired
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
         $error("CNT_W must be 1..16");
      end
      if (INIT_VAL < 1 || INIT_VAL >= (1 << CNT_W)) begin : g_bad_init
         $error("INIT_VAL must be nonzero and fit in CNT_W bits");
      end
   endgenerate

   logic any_zero;
   logic load_ok;

   assign load_ok = load_en & ~fault;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic hit;
         assign hit = load_ok && (load_idx == IDX_W'(i));
         vwdog_channel #(
            .CNT_W    (CNT_W),
            .INIT_VAL (INIT_VAL)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_hit (hit),
            .load_val (load_val),
            .tick     (tick),
            .zero_o   (expired[i])
         );
      end
   endgenerate

   vwdog_any_zero #(
      .NUM_CH (NUM_CH),
      .TREE   (OR_TREE)
   ) u_any (
      .vec_i  (expired),
      .any_o  (any_zero)
   );

   vwdog_kick_ctrl u_kick (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .any_zero (any_zero),
      .kick     (kick),
      .fault    (fault)
   );

endmodule

// File: rtl/vwdog_aggregator_chk.sv
module vwdog_aggregator_chk #(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              kick,
   input logic              fault,
   input logic [NUM_CH-1:0] expired
);

   // R5
   kick_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |-> $past(tick));

   // R5
   no_kick_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |-> (!fault && expired == '0));

   // R6
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   // R6
   fault_follows_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired != '0) |=> fault);

   // R7
   no_revive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> ((expired & $past(expired)) == $past(expired)));

endmodule

bind vwdog_aggregator vwdog_aggregator_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .kick    (kick),
   .fault   (fault),
   .expired (expired)
);

// File: tb/vwdog_aggregator_bench.sv
module vwdog_aggregator_bench;

   localparam int CLK_P = 10;
   localparam int NCH   = 3;
   localparam int CW    = 4;
   localparam int INIT  = 7;
   localparam int IW    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [IW-1:0] load_idx = '0;
   logic [CW-1:0] load_val = '0;
   logic          tick = 1'b0;
   logic          kick;
   logic          fault;
   logic [NCH-1:0] expired;

   int n_run = 0;
   int n_fail = 0;

   int m_cnt [NCH];
   bit m_fault;
   bit m_kick;

   always #(CLK_P/2) clk = ~clk;

   vwdog_aggregator #(
      .NUM_CH   (NCH),
      .CNT_W    (CW),
      .INIT_VAL (INIT)
   ) u_vwdog_aggregator (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .load_idx (load_idx),
      .load_val (load_val),
      .tick     (tick),
      .kick     (kick),
      .fault    (fault),
      .expired  (expired)
   );

   function automatic bit m_anyzero();
      for (int i = 0; i < NCH; i++) if (m_cnt[i] == 0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [NCH-1:0] m_exp();
      logic [NCH-1:0] v;
      for (int i = 0; i < NCH; i++) v[i] = (m_cnt[i] == 0);
      return v;
   endfunction

   task automatic check_all(input string req);
      n_run += 3;
      if (expired !== m_exp()) begin
         n_fail++;
         $display("FAIL %s expired: got %b expected %b", req, expired, m_exp());
      end
      if (fault !== m_fault) begin
         n_fail++;
         $display("FAIL %s fault: got %b expected %b", req, fault, m_fault);
      end
      if (kick !== m_kick) begin
         n_fail++;
         $display("FAIL %s kick: got %b expected %b", req, kick, m_kick);
      end
   endtask

   // Called at a negedge: drive, advance the model at the edge, check at the next negedge.
   task automatic step(input bit le, input int idx, input int val, input bit tk, input string req);
      bit old_fault;
      load_en  = le;
      load_idx = IW'(idx);
      load_val = CW'(val);
      tick     = tk;
      @(posedge clk);
      old_fault = m_fault;
      m_fault = m_fault | m_anyzero();
      for (int i = 0; i < NCH; i++) begin
         if (le && idx == i && !old_fault) m_cnt[i] = val;
         else if (tk && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
      end
      m_kick = tk && !m_anyzero() && !m_fault;
      @(negedge clk);
      check_all(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; load_en = 1'b0; tick = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NCH; i++) m_cnt[i] = INIT;
      m_fault = 1'b0; m_kick = 1'b0;
      check_all("R1");
   endtask

   bit done = 1'b0;

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 and plain ticking from the reset value (R3, R5, R6)
      do_reset();
      for (int t = 0; t < INIT + 3; t++) step(1'b0, 0, 0, 1'b1, "R3");
      step(1'b0, 0, 0, 1'b0, "R6");

      // Sweep every channel and short load values (R2, R3, R5, R6, R7, R8)
      for (int ch = 0; ch < NCH; ch++) begin
         for (int v = 0; v < 5; v++) begin
            do_reset();
            for (int o = 0; o < NCH; o++)
               if (o != ch) step(1'b1, o, 12, 1'b0, "R2");
            step(1'b1, ch, v, 1'b0, "R2");
            for (int t = 0; t < v + 2; t++) step(1'b0, 0, 0, 1'b1, "R8");
            step(1'b1, ch, 9, 1'b0, "R7");
            step(1'b1, ch, 9, 1'b1, "R7");
            step(1'b0, 0, 0, 1'b1, "R3");
         end
      end

      // Write and tick together on one channel, then on another (R4)
      do_reset();
      step(1'b1, 1, 2, 1'b0, "R4");
      for (int t = 0; t < 4; t++) step(1'b1, 1, 2, 1'b1, "R4");
      step(1'b1, 0, 3, 1'b1, "R4");
      step(1'b0, 0, 0, 1'b1, "R4");
      step(1'b0, 0, 0, 1'b1, "R4");
      step(1'b0, 0, 0, 1'b1, "R4");

      // Out-of-range index has no effect (R9)
      do_reset();
      step(1'b1, 3, 0, 1'b0, "R9");
      step(1'b1, 3, 0, 1'b1, "R9");
      step(1'b0, 0, 0, 1'b0, "R9");

      // Kicks on spaced ticks, no write (R5)
      do_reset();
      for (int t = 0; t < 6; t++) begin
         step(1'b0, 0, 0, 1'b1, "R5");
         step(1'b0, 0, 0, 1'b0, "R5");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule